// File: doc/BRIEF.md
# D-PHY Lane Timing Counter Generator

This block turns a lane bit rate, given in Mbit/s, into the counter settings that a D-PHY transmitter needs for low-power to high-speed entry, high-speed exit and bus turnaround. It then streams those settings as masked byte-wide field writes into the register parts of the clock lane and the four data lanes. Some values are computed from the rate: the byte clock is the rate divided by 8, and the escape clock is the byte clock divided by an integer that keeps it at or below 20 MHz. Each nanosecond limit is converted to a clock count and rounded up. The prepare, zero and trail counts come instead from a rate-banded table.

A variant input selects one of two transmitter classes, a 1 GHz class and a 2.5 GHz class. The 2.5 GHz class uses its own band table and takes its LPX count from that table. It also widens three counters by writing their top bits into separate high fields. The block is started by a single-cycle pulse. It computes for a few cycles, emits one write per clock with no gaps, and then pulses `done`.

Top module: `dphy_lane_timer`

## Requirements
- R1: A `start` pulse while idle captures `lane_mbps` and `fast_variant` and raises `busy` on the next cycle. A `start` while `busy` is high is ignored: the write stream already under way is unchanged.
- R2: Writes go to lane parts in this order: 2 (clock lane), then 3, 4, 5, 6 (data lanes 0 to 3), with `wr_addr = {part[2:0], reg[4:0]}`. Within a part, writes follow ascending register order, and the lower-mask field comes first where two fields share a register. There is one write per clock with no gaps. The first write appears within 16 cycles of `start`. Data bits outside `wr_mask` are zero.
- R3: In the 1 GHz class (`fast_variant`=0), each part gets 12 writes. In the 2.5 GHz class, each part gets 15 writes, the extra three being the high fields named in R4, R5 and R9.
- R4: The HS-exit count is ceil(3R/200) for rate R. Its bits [4:0] go to reg 0x09, mask 0x1F. In the 2.5 GHz class only, its bit 5 goes to reg 0x11 bit 6, mask 0x40.
- R5: The clock-post count is ceil((7R+5200)/800). Its bits [3:0] go to reg 0x0A, mask 0x0F. In the 2.5 GHz class only, its bits [5:4] go to reg 0x10 bits [7:6], mask 0xC0. The clock-pre count is 1 and goes to reg 0x0E, mask 0x0F.
- R6: The LPX value goes to reg 0x05, mask 0x3F. In the 1 GHz class it is c = ceil(3R/400), reduced by 2 only when c is at least 2. In the 2.5 GHz class it is the LPX column of the selected band.
- R7: The escape divider is D = ceil(R/160), held at a minimum of 1. The turnaround counts are:
  - TA-go = ceil(3R/(100D)), written to reg 0x10, mask 0x3F.
  - TA-sure = ceil(3R/(200D)), written to reg 0x11, mask 0x3F.
  - TA-wait = ceil(3R/(80D)), written to reg 0x12, mask 0x3F.
- R8: The band is the first row, in ascending rate order, whose limit is at or above R. If no row qualifies, the last row is used. The band's prepare value goes to reg 0x06, mask 0x7F, and its trail value goes to reg 0x08, mask 0x7F.
- R9: The HS-zero value is the band's clock-zero value for part 2 and the band's data-zero value for parts 3 to 6. Its bits [5:0] go to reg 0x07, mask 0x3F. In the 2.5 GHz class only, its bit 6 goes to reg 0x06 bit 7, mask 0x80.
- R10: The wakeup count is fixed at 0x3FF. Its top two bits go to reg 0x0C, mask 0x03, data 0x03. Its low byte goes to reg 0x0D, mask 0xFF, data 0xFF.
- R11: `done` is high for exactly one cycle, in the cycle right after the last write. `busy` stays high through that cycle and is low on the next.
- R12: After reset, `busy`, `wr_valid` and `done` are low.

## Band tables
Rows give limit (Mbit/s): LPX / prepare / clock-zero / data-zero / trail, in hex.

1 GHz class: 110: -/20/16/02/22, 150: -/06/16/03/45, 200: -/18/17/04/0b, 250: -/05/17/05/16, 300: -/51/18/06/2c, 400: -/64/19/07/33, 500: -/20/1b/07/4e, 600: -/6a/1d/08/3a, 700: -/3e/1e/08/6a, 800: -/21/1f/09/29, 1000: -/09/20/09/27.

2.5 GHz class: 110: 02/7f/16/02/02, 150: 02/7f/16/03/02, 200: 02/7f/17/04/02, 250: 02/7f/17/05/04, 300: 02/7f/18/06/04, 400: 03/7e/19/07/04, 500: 03/7c/1b/07/08, 600: 03/70/1d/08/10, 700: 05/40/1e/08/30, 800: 05/02/1f/09/30, 1000: 05/08/20/09/30, 1200: 06/03/32/14/0f, 1400: 09/03/32/14/0f, 1600: 0d/42/36/0e/0f, 1800: 0e/47/7a/0e/0f, 2000: 11/64/7a/0e/0b, 2200: 13/64/7e/15/0b, 2400: 13/33/7f/15/6a, 2500: 15/54/7f/15/6a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| lane_mbps | input | RATE_W | Lane bit rate in Mbit/s |
| fast_variant | input | 1 | 1 selects the 2.5 GHz class, 0 selects the 1 GHz class |
| busy | output | 1 | High from the cycle after start through the done cycle |
| wr_valid | output | 1 | A field write is presented this cycle |
| wr_addr | output | 8 | Lane part in bits [7:5], register in bits [4:0] |
| wr_mask | output | 8 | Bits of the register owned by this write |
| wr_data | output | 8 | Field value, already placed under the mask |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
Two situations are hard to reach from the ports. The first is the rate band edges: a rate exactly on a row limit must select that row, and one above it must select the next. The second is rates beyond the top row, which must fall back to the last row. The stimulus therefore drives rates on and just past limits in both classes, including the full-scale 4095. It also drives very low rates, where the LPX offset is not subtracted and the escape divider is at its floor of 1. A second `start` carrying a different rate is injected in the middle of a run to show that the stream in flight is left untouched.

// File: rtl/dphy_lane_timer.sv
module dphy_lane_timer #(
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] lane_mbps,
  input  logic              fast_variant,
  output logic              busy,
  output logic              wr_valid,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_mask,
  output logic [7:0]        wr_data,
  output logic              done
);

  localparam int SLOW_N = 11;
  localparam int FAST_N = 19;
  localparam int NTA = 3;
  localparam logic [9:0] WAKE = 10'h3FF;
  localparam logic [3:0] CLK_PRE = 4'd1;
  localparam logic [3:0] LAST_STEP = 4'd14;
  localparam logic [2:0] LAST_LANE = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_WRITE, S_DONE} state_t;

  state_t            state;
  logic [RATE_W-1:0] rate_q;
  logic              fast_q;
  logic [2:0]        lane_q;
  logic [3:0]        step_q;
  logic [31:0]       acc [NTA];
  logic [5:0]        ta_q [NTA];

  logic [31:0] rate32, num, esc_div;
  logic [31:0] div_m [NTA];
  logic        calc_open;
  logic [5:0]  hs_exit, clk_post, lpx_raw, lpx;
  logic [45:0] row, cand;
  logic        hit;
  logic [6:0]  hs_zero;
  logic [4:0]  reg_sel;
  logic [7:0]  field;
  logic [3:0]  step_nxt;

  // {limit[11:0], lpx[5:0], prepare[6:0], clk_zero[6:0], data_zero[6:0], trail[6:0]}
  function automatic logic [45:0] slow_row(input int i);
    case (i)
      0:  return {12'd110,  6'h0, 7'h20, 7'h16, 7'h02, 7'h22};
      1:  return {12'd150,  6'h0, 7'h06, 7'h16, 7'h03, 7'h45};
      2:  return {12'd200,  6'h0, 7'h18, 7'h17, 7'h04, 7'h0b};
      3:  return {12'd250,  6'h0, 7'h05, 7'h17, 7'h05, 7'h16};
      4:  return {12'd300,  6'h0, 7'h51, 7'h18, 7'h06, 7'h2c};
      5:  return {12'd400,  6'h0, 7'h64, 7'h19, 7'h07, 7'h33};
      6:  return {12'd500,  6'h0, 7'h20, 7'h1b, 7'h07, 7'h4e};
      7:  return {12'd600,  6'h0, 7'h6a, 7'h1d, 7'h08, 7'h3a};
      8:  return {12'd700,  6'h0, 7'h3e, 7'h1e, 7'h08, 7'h6a};
      9:  return {12'd800,  6'h0, 7'h21, 7'h1f, 7'h09, 7'h29};
      default: return {12'd1000, 6'h0, 7'h09, 7'h20, 7'h09, 7'h27};
    endcase
  endfunction

  function automatic logic [45:0] fast_row(input int i);
    case (i)
      0:  return {12'd110,  6'h02, 7'h7f, 7'h16, 7'h02, 7'h02};
      1:  return {12'd150,  6'h02, 7'h7f, 7'h16, 7'h03, 7'h02};
      2:  return {12'd200,  6'h02, 7'h7f, 7'h17, 7'h04, 7'h02};
      3:  return {12'd250,  6'h02, 7'h7f, 7'h17, 7'h05, 7'h04};
      4:  return {12'd300,  6'h02, 7'h7f, 7'h18, 7'h06, 7'h04};
      5:  return {12'd400,  6'h03, 7'h7e, 7'h19, 7'h07, 7'h04};
      6:  return {12'd500,  6'h03, 7'h7c, 7'h1b, 7'h07, 7'h08};
      7:  return {12'd600,  6'h03, 7'h70, 7'h1d, 7'h08, 7'h10};
      8:  return {12'd700,  6'h05, 7'h40, 7'h1e, 7'h08, 7'h30};
      9:  return {12'd800,  6'h05, 7'h02, 7'h1f, 7'h09, 7'h30};
      10: return {12'd1000, 6'h05, 7'h08, 7'h20, 7'h09, 7'h30};
      11: return {12'd1200, 6'h06, 7'h03, 7'h32, 7'h14, 7'h0f};
      12: return {12'd1400, 6'h09, 7'h03, 7'h32, 7'h14, 7'h0f};
      13: return {12'd1600, 6'h0d, 7'h42, 7'h36, 7'h0e, 7'h0f};
      14: return {12'd1800, 6'h0e, 7'h47, 7'h7a, 7'h0e, 7'h0f};
      15: return {12'd2000, 6'h11, 7'h64, 7'h7a, 7'h0e, 7'h0b};
      16: return {12'd2200, 6'h13, 7'h64, 7'h7e, 7'h15, 7'h0b};
      17: return {12'd2400, 6'h13, 7'h33, 7'h7f, 7'h15, 7'h6a};
      default: return {12'd2500, 6'h15, 7'h54, 7'h7f, 7'h15, 7'h6a};
    endcase
  endfunction

  assign rate32   = 32'(rate_q);
  assign num      = rate32 * 32'd3;
  assign esc_div  = ((rate32 + 32'd159) / 32'd160 == 32'd0) ? 32'd1 : (rate32 + 32'd159) / 32'd160;
  assign div_m[0] = esc_div * 32'd100;
  assign div_m[1] = esc_div * 32'd200;
  assign div_m[2] = esc_div * 32'd80;
  assign calc_open = (acc[0] < num) || (acc[1] < num) || (acc[2] < num);

  assign hs_exit  = 6'((num + 32'd199) / 32'd200);
  assign clk_post = 6'((rate32 * 32'd7 + 32'd5999) / 32'd800);
  assign lpx_raw  = 6'((num + 32'd399) / 32'd400);

  always_comb begin
    row  = fast_q ? fast_row(FAST_N - 1) : slow_row(SLOW_N - 1);
    hit  = 1'b0;
    cand = row;
    for (int i = 0; i < FAST_N; i++) begin
      cand = fast_q ? fast_row(i) : slow_row(i);
      if (!hit && rate32 <= 32'(cand[45:34])) begin
        row = cand;
        hit = 1'b1;
      end
    end
  end

  assign lpx     = fast_q ? row[33:28] : ((lpx_raw >= 6'd2) ? lpx_raw - 6'd2 : lpx_raw);
  assign hs_zero = (lane_q == 3'd0) ? row[20:14] : row[13:7];

  always_comb begin
    reg_sel = 5'h12;
    wr_mask = 8'h3F;
    field   = {2'b0, ta_q[2]};
    case (step_q)
      4'd0:  begin reg_sel = 5'h05; wr_mask = 8'h3F; field = {2'b0, lpx}; end
      4'd1:  begin reg_sel = 5'h06; wr_mask = 8'h7F; field = {1'b0, row[27:21]}; end
      4'd2:  begin reg_sel = 5'h06; wr_mask = 8'h80; field = {hs_zero[6], 7'b0}; end
      4'd3:  begin reg_sel = 5'h07; wr_mask = 8'h3F; field = {2'b0, hs_zero[5:0]}; end
      4'd4:  begin reg_sel = 5'h08; wr_mask = 8'h7F; field = {1'b0, row[6:0]}; end
      4'd5:  begin reg_sel = 5'h09; wr_mask = 8'h1F; field = {3'b0, hs_exit[4:0]}; end
      4'd6:  begin reg_sel = 5'h0A; wr_mask = 8'h0F; field = {4'b0, clk_post[3:0]}; end
      4'd7:  begin reg_sel = 5'h0C; wr_mask = 8'h03; field = {6'b0, WAKE[9:8]}; end
      4'd8:  begin reg_sel = 5'h0D; wr_mask = 8'hFF; field = WAKE[7:0]; end
      4'd9:  begin reg_sel = 5'h0E; wr_mask = 8'h0F; field = {4'b0, CLK_PRE}; end
      4'd10: begin reg_sel = 5'h10; wr_mask = 8'h3F; field = {2'b0, ta_q[0]}; end
      4'd11: begin reg_sel = 5'h10; wr_mask = 8'hC0; field = {clk_post[5:4], 6'b0}; end
      4'd12: begin reg_sel = 5'h11; wr_mask = 8'h3F; field = {2'b0, ta_q[1]}; end
      4'd13: begin reg_sel = 5'h11; wr_mask = 8'h40; field = {1'b0, hs_exit[5], 6'b0}; end
      default: ;
    endcase
  end

  assign wr_addr  = {3'(lane_q + 3'd2), reg_sel};
  assign wr_data  = field & wr_mask;
  assign busy     = (state != S_IDLE);
  assign wr_valid = (state == S_WRITE);
  assign done     = (state == S_DONE);

  always_comb begin
    step_nxt = step_q + 4'd1;
    if (!fast_q && (step_nxt == 4'd2 || step_nxt == 4'd11 || step_nxt == 4'd13))
      step_nxt = step_q + 4'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rate_q <= '0;
      fast_q <= 1'b0;
      lane_q <= '0;
      step_q <= '0;
      for (int i = 0; i < NTA; i++) begin
        acc[i]  <= '0;
        ta_q[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (start) begin
          rate_q <= lane_mbps;
          fast_q <= fast_variant;
          for (int i = 0; i < NTA; i++) begin
            acc[i]  <= '0;
            ta_q[i] <= '0;
          end
          state <= S_CALC;
        end
        S_CALC: begin
          if (calc_open) begin
            for (int i = 0; i < NTA; i++)
              if (acc[i] < num) begin
                acc[i]  <= acc[i] + div_m[i];
                ta_q[i] <= ta_q[i] + 6'd1;
              end
          end else begin
            lane_q <= '0;
            step_q <= '0;
            state  <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (step_q == LAST_STEP) begin
            step_q <= '0;
            if (lane_q == LAST_LANE) state <= S_DONE;
            else lane_q <= lane_q + 3'd1;
          end else begin
            step_q <= step_nxt;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dphy_lane_timer_chk.sv
module dphy_lane_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wr_valid,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_mask,
  input logic [7:0] wr_data,
  input logic       done
);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !done));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid));

  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r2_data_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_data & ~wr_mask) == 8'h00));

  a_r2_part_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[7:5] >= 3'd2 && wr_addr[7:5] <= 3'd6));

  a_r10_wake_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr[4:0] == 5'h0D) |-> (wr_data == 8'hFF && wr_mask == 8'hFF));

endmodule

bind dphy_lane_timer dphy_lane_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_mask  (wr_mask),
  .wr_data  (wr_data),
  .done     (done)
);

// File: tb/dphy_lane_timer_test.sv
module dphy_lane_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] lane_mbps = '0;
  logic        fast_variant = 1'b0;
  logic        busy, wr_valid, done;
  logic [7:0]  wr_addr, wr_mask, wr_data;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  dphy_lane_timer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_mbps(lane_mbps),
    .fast_variant(fast_variant), .busy(busy), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data), .done(done)
  );

  int sl_lim[11]  = '{110,150,200,250,300,400,500,600,700,800,1000};
  int sl_prep[11] = '{'h20,'h06,'h18,'h05,'h51,'h64,'h20,'h6a,'h3e,'h21,'h09};
  int sl_cz[11]   = '{'h16,'h16,'h17,'h17,'h18,'h19,'h1b,'h1d,'h1e,'h1f,'h20};
  int sl_dz[11]   = '{'h02,'h03,'h04,'h05,'h06,'h07,'h07,'h08,'h08,'h09,'h09};
  int sl_tr[11]   = '{'h22,'h45,'h0b,'h16,'h2c,'h33,'h4e,'h3a,'h6a,'h29,'h27};

  int fs_lim[19]  = '{110,150,200,250,300,400,500,600,700,800,1000,1200,1400,1600,1800,2000,2200,2400,2500};
  int fs_lpx[19]  = '{2,2,2,2,2,3,3,3,5,5,5,6,9,'h0d,'h0e,'h11,'h13,'h13,'h15};
  int fs_prep[19] = '{'h7f,'h7f,'h7f,'h7f,'h7f,'h7e,'h7c,'h70,'h40,'h02,'h08,'h03,'h03,'h42,'h47,'h64,'h64,'h33,'h54};
  int fs_cz[19]   = '{'h16,'h16,'h17,'h17,'h18,'h19,'h1b,'h1d,'h1e,'h1f,'h20,'h32,'h32,'h36,'h7a,'h7a,'h7e,'h7f,'h7f};
  int fs_dz[19]   = '{'h02,'h03,'h04,'h05,'h06,'h07,'h07,'h08,'h08,'h09,'h09,'h14,'h14,'h0e,'h0e,'h0e,'h15,'h15,'h15};
  int fs_tr[19]   = '{'h02,'h02,'h02,'h04,'h04,'h04,'h08,'h10,'h30,'h30,'h30,'h0f,'h0f,'h0f,'h0f,'h0b,'h0b,'h6a,'h6a};

  int    exp_addr[$];
  int    exp_mask[$];
  int    exp_data[$];
  string exp_tag[$];

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(int part, int rg, int mask, int val, string tag);
    exp_addr.push_back(part * 32 + rg);
    exp_mask.push_back(mask);
    exp_data.push_back(val & mask);
    exp_tag.push_back(tag);
  endtask

  task automatic build(int r, bit fast);
    int d, ex, post, raw, lp, go, sure, wt, idx, prep, cz, dz, tr, zr;
    exp_addr.delete(); exp_mask.delete(); exp_data.delete(); exp_tag.delete();
    d = cdiv(r, 160);
    if (d < 1) d = 1;
    ex   = cdiv(3 * r, 200);
    post = cdiv(7 * r + 5200, 800);
    raw  = cdiv(3 * r, 400);
    go   = cdiv(3 * r, 100 * d);
    sure = cdiv(3 * r, 200 * d);
    wt   = cdiv(3 * r, 80 * d);
    if (fast) begin
      idx = 18;
      for (int i = 18; i >= 0; i--) if (r <= fs_lim[i]) idx = i;
      lp = fs_lpx[idx]; prep = fs_prep[idx]; cz = fs_cz[idx]; dz = fs_dz[idx]; tr = fs_tr[idx];
    end else begin
      idx = 10;
      for (int i = 10; i >= 0; i--) if (r <= sl_lim[i]) idx = i;
      lp = (raw >= 2) ? raw - 2 : raw;
      prep = sl_prep[idx]; cz = sl_cz[idx]; dz = sl_dz[idx]; tr = sl_tr[idx];
    end
    for (int p = 0; p < 5; p++) begin
      zr = (p == 0) ? cz : dz;
      push(p + 2, 'h05, 'h3F, lp, "R6");
      push(p + 2, 'h06, 'h7F, prep, "R8");
      if (fast) push(p + 2, 'h06, 'h80, ((zr >> 6) & 1) << 7, "R9");
      push(p + 2, 'h07, 'h3F, zr, "R9");
      push(p + 2, 'h08, 'h7F, tr, "R8");
      push(p + 2, 'h09, 'h1F, ex, "R4");
      push(p + 2, 'h0A, 'h0F, post, "R5");
      push(p + 2, 'h0C, 'h03, 3, "R10");
      push(p + 2, 'h0D, 'hFF, 'hFF, "R10");
      push(p + 2, 'h0E, 'h0F, 1, "R5");
      push(p + 2, 'h10, 'h3F, go, "R7");
      if (fast) push(p + 2, 'h10, 'hC0, ((post >> 4) & 3) << 6, "R5");
      push(p + 2, 'h11, 'h3F, sure, "R7");
      if (fast) push(p + 2, 'h11, 'h40, ((ex >> 5) & 1) << 6, "R4");
      push(p + 2, 'h12, 'h3F, wt, "R7");
    end
  endtask

  task automatic run(int r, bit fast, bit inject);
    int  total, seen, cyc, first_at;
    bit  finished;
    build(r, fast);
    total = exp_addr.size();
    check(total == (fast ? 75 : 60), "R3", "write count", total, fast ? 75 : 60);
    @(negedge clk);
    lane_mbps = 12'(r); fast_variant = fast; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lane_mbps = 12'd7; fast_variant = ~fast;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    seen = 0; cyc = 1; first_at = -1; finished = 0;
    while (!finished && cyc < 300) begin
      if (inject && cyc == 20) start = 1'b1;
      if (inject && cyc == 21) start = 1'b0;
      if (wr_valid) begin
        if (first_at < 0) begin
          first_at = cyc;
          check(cyc <= 16, "R2", "first write latency", cyc, 16);
        end
        if (seen < total) begin
          check(wr_addr == 8'(exp_addr[seen]), exp_tag[seen], "wr_addr", wr_addr, exp_addr[seen]);
          check(wr_mask == 8'(exp_mask[seen]), exp_tag[seen], "wr_mask", wr_mask, exp_mask[seen]);
          check(wr_data == 8'(exp_data[seen]), exp_tag[seen], "wr_data", wr_data, exp_data[seen]);
        end else begin
          check(0, "R2", "extra write", seen, total);
        end
        seen++;
      end else if (first_at >= 0 && seen < total) begin
        check(0, "R2", "gap in write stream", seen, total);
        finished = 1;
      end else if (seen == total) begin
        check(done == 1'b1, "R11", "done after last write", done, 1);
        check(busy == 1'b1, "R11", "busy in done cycle", busy, 1);
        @(negedge clk);
        check(done == 1'b0, "R11", "done single pulse", done, 0);
        check(busy == 1'b0, "R11", "idle after done", busy, 0);
        finished = 1;
      end
      if (!finished) begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    if (!finished) check(0, "R11", "run timed out", cyc, 300);
    check(seen == total, "R3", "writes seen", seen, total);
    if (inject) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1", "start while busy ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && wr_valid == 1'b0 && done == 1'b0, "R12", "reset outputs",
          {busy, wr_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && wr_valid == 1'b0, "R12", "idle after reset", {busy, wr_valid}, 0);
    // 1 GHz class: low rates, band edges, beyond last band
    run(1,    1'b0, 1'b0);
    run(80,   1'b0, 1'b0);
    run(110,  1'b0, 1'b0);
    run(111,  1'b0, 1'b0);
    run(480,  1'b0, 1'b1);
    run(1000, 1'b0, 1'b0);
    run(1500, 1'b0, 1'b0);
    // 2.5 GHz class: edges, high fields, full scale
    run(110,  1'b1, 1'b0);
    run(1200, 1'b1, 1'b0);
    run(1201, 1'b1, 1'b1);
    run(2500, 1'b1, 1'b0);
    run(2501, 1'b1, 1'b0);
    run(4095, 1'b1, 1'b0);
    run(0,    1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule